// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block merges the interrupt sources of an audio controller into a single 32-bit status word and turns that word into an interrupt request. Each DMA stream contributes a buffer-completion flag on its own status bit. A controller-summary bit combines three unrelated sources: the response-ring interrupt flag, the response-ring overrun flag, and any codec wake-status bit whose enable is set. The top bit is the global summary. It is set when any lower status bit is also enabled in the interrupt-control register.

The request can leave the block in one of two ways. In line mode the level drives the interrupt wire directly. In message mode a notifier state machine emits one single-cycle pulse per rising edge of the level, so a level that stays high does not produce repeated messages. The notifier has three states. NTF_IDLE means the level was low at the last edge. NTF_FIRE is the one cycle in which the pulse is output. NTF_HOLD means the level is high and no pulse is due. Its transitions are as follows. IDLE goes to FIRE on a high level in message mode. IDLE goes to HOLD on a high level in line mode. FIRE goes to HOLD when the level stays high, and to IDLE when it falls. HOLD goes to IDLE when the level falls.

The block also holds the interrupt-control register, the wake-enable register and the write-1-to-clear wake-status register. Synchronous reset presets the wake-status register from the set of present codec addresses.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the interrupt-control and wake-enable registers load 0, wake status loads `codec_present`, and the notifier returns to idle. The first cycle after reset shows these values, with `irq_line` and `irq_msg` low when no source is active.
- R2: A write to the interrupt-control register stores only the bits in mask 0xC00000FF: bit 31 is the global enable, bit 30 enables the controller summary, and bits 7..0 enable streams 7..0. All other bits read 0.
- R3: Status bits 7..0 equal `stream_done[7:0]` in the same cycle, and status bits 29..8 are always 0.
- R4: Status bit 30 is 1 in the same cycle when `rsp_irq`, `rsp_ovr`, or any bit of (wake status AND wake enable) is 1.
- R5: Status bit 31 is 1 exactly when status bits 30..0 ANDed with control bits 30..0 are nonzero. Control bit 31 does not affect status bit 31.
- R6: With `msg_mode` low, `irq_line` equals status bit 31 AND control bit 31 in the same cycle.
- R7: Writing the wake-status register clears each bit written as 1 and leaves bits written as 0 unchanged; no bit is ever set after reset. Wake enable stores the low 15 bits of its write data.
- R8: With `msg_mode` high, `irq_line` stays low. `irq_msg` is high for exactly one cycle, in the cycle after the first clock edge at which the level (status bit 31 AND control bit 31) is seen high. A level that remains high gives no further pulse.
- R9: After the level has been low at a clock edge, a new rising edge gives another pulse. Switching into message mode while the level is already high gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| codec_present | input | 15 | One bit per codec address that is present; loaded into wake status on reset |
| rsp_irq | input | 1 | Response-ring interrupt status |
| rsp_ovr | input | 1 | Response-ring overrun status |
| stream_done | input | 8 | Buffer-completion flag of each stream |
| ctl_wr_en | input | 1 | Write strobe for the interrupt-control register |
| ctl_wr_data | input | 32 | Interrupt-control write data |
| wen_wr_en | input | 1 | Write strobe for wake enable |
| wen_wr_data | input | 15 | Wake-enable write data |
| wsts_wr_en | input | 1 | Write strobe for wake status (write 1 to clear) |
| wsts_wr_data | input | 15 | Wake-status clear mask |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| int_ctl | output | 32 | Interrupt-control register value |
| wake_en | output | 15 | Wake-enable register value |
| wake_sts | output | 15 | Wake-status register value |
| int_status | output | 32 | Computed interrupt status word |
| irq_line | output | 1 | Level interrupt output (line mode) |
| irq_msg | output | 1 | Single-cycle message request (message mode) |

## Verification
The bench targets the places where the two-stage gating is easy to get wrong. It sets a stream enable without the global enable and checks that status bit 31 rises while the line stays low; a design that folded the global enable into the summary would clear bit 31. It drives wake bits that are set but not enabled, and the reverse, where a design missing the AND would raise the controller-summary bit. It holds the level high for several cycles and re-arms it to catch a pulser that repeats or never re-arms. It switches into message mode under a high level, where a design that detected level instead of edges would send a spurious message. It applies a second reset with a different codec set, which exposes a wake-status preset wired to a constant.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
    localparam int unsigned STS_W       = 32;
    localparam int unsigned CTL_SUM_BIT = 30;
    localparam int unsigned GLB_BIT     = 31;

    typedef enum logic [1:0] {
        NTF_IDLE = 2'd0,
        NTF_FIRE = 2'd1,
        NTF_HOLD = 2'd2
    } ntf_state_e;
endpackage

// File: rtl/irq_wake_regs.sv
`timescale 1ns/1ps
module irq_wake_regs #(
    parameter int unsigned WAKE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAKE_W-1:0] codec_present,
    input  logic              wen_we,
    input  logic [WAKE_W-1:0] wen_wd,
    input  logic              wsts_we,
    input  logic [WAKE_W-1:0] wsts_wd,
    output logic [WAKE_W-1:0] wake_en,
    output logic [WAKE_W-1:0] wake_sts
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en  <= '0;
            wake_sts <= codec_present;
        end else begin
            if (wen_we) begin
                wake_en <= wen_wd;
            end
            if (wsts_we) begin
                wake_sts <= wake_sts & ~wsts_wd;
            end
        end
    end

    // R7: every bit written as 1 is clear in the next cycle
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wsts_we |=> ((wake_sts & $past(wsts_wd)) == '0));

    // R7: no wake-status bit sets outside reset
    a_r7_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((wake_sts & ~$past(wake_sts)) == '0));
endmodule

// File: rtl/irq_ctl_reg.sv
`timescale 1ns/1ps
module irq_ctl_reg
    import irq_agg_pkg::*;
#(
    parameter logic [STS_W-1:0] WR_MASK = 32'hC00000FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [STS_W-1:0] wd,
    output logic [STS_W-1:0] ctl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl <= wd & WR_MASK;
        end
    end

    // R2: a write lands masked
    a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl == ($past(wd) & WR_MASK)));

    // R2: without a write the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ctl));
endmodule

// File: rtl/irq_status_calc.sv
`timescale 1ns/1ps
module irq_status_calc
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned WAKE_W      = 15
) (
    input  logic [NUM_STREAMS-1:0] stream_done,
    input  logic                   rsp_irq,
    input  logic                   rsp_ovr,
    input  logic [WAKE_W-1:0]      wake_en,
    input  logic [WAKE_W-1:0]      wake_sts,
    input  logic [STS_W-1:0]       ctl,
    output logic [STS_W-1:0]       status
);
    logic [GLB_BIT-1:0] src;
    logic               ctl_sum;

    assign ctl_sum = rsp_irq | rsp_ovr | (|(wake_sts & wake_en));

    for (genvar b = 0; b < GLB_BIT; b++) begin : g_src
        if (b < NUM_STREAMS) begin : g_stream
            assign src[b] = stream_done[b];
        end else if (b == CTL_SUM_BIT) begin : g_sum
            assign src[b] = ctl_sum;
        end else begin : g_zero
            assign src[b] = 1'b0;
        end
    end

    always_comb begin
        status          = {1'b0, src};
        status[GLB_BIT] = |(src & ctl[GLB_BIT-1:0]);
    end
endmodule

// File: rtl/irq_notify_fsm.sv
`timescale 1ns/1ps
module irq_notify_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic msg_mode,
    output logic irq_msg
);
    ntf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NTF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NTF_IDLE: begin
                if (level) begin
                    state_d = msg_mode ? NTF_FIRE : NTF_HOLD;
                end
            end
            NTF_FIRE: state_d = level ? NTF_HOLD : NTF_IDLE;
            NTF_HOLD: begin
                if (!level) begin
                    state_d = NTF_IDLE;
                end
            end
            default:  state_d = NTF_IDLE;
        endcase
    end

    always_comb begin
        irq_msg = (state_q == NTF_FIRE);
    end

    // R8: a message pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |=> !irq_msg);

    // R8: a pulse follows a high level seen in message mode
    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |-> ($past(level) && $past(msg_mode)));

    // R9: a held level never fires a second time
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (level && $past(level)) |=> !irq_msg);
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned WAKE_W      = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WAKE_W-1:0]      codec_present,
    input  logic                   rsp_irq,
    input  logic                   rsp_ovr,
    input  logic [NUM_STREAMS-1:0] stream_done,
    input  logic                   ctl_wr_en,
    input  logic [STS_W-1:0]       ctl_wr_data,
    input  logic                   wen_wr_en,
    input  logic [WAKE_W-1:0]      wen_wr_data,
    input  logic                   wsts_wr_en,
    input  logic [WAKE_W-1:0]      wsts_wr_data,
    input  logic                   msg_mode,
    output logic [STS_W-1:0]       int_ctl,
    output logic [WAKE_W-1:0]      wake_en,
    output logic [WAKE_W-1:0]      wake_sts,
    output logic [STS_W-1:0]       int_status,
    output logic                   irq_line,
    output logic                   irq_msg
);
    localparam logic [STS_W-1:0] STREAM_BITS = STS_W'((64'd1 << NUM_STREAMS) - 64'd1);
    localparam logic [STS_W-1:0] CTL_MASK    =
        (STS_W'(1) << GLB_BIT) | (STS_W'(1) << CTL_SUM_BIT) | STREAM_BITS;

    logic level;

    irq_ctl_reg #(.WR_MASK(CTL_MASK)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_wr_en),
        .wd    (ctl_wr_data),
        .ctl   (int_ctl)
    );

    irq_wake_regs #(.WAKE_W(WAKE_W)) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .codec_present (codec_present),
        .wen_we        (wen_wr_en),
        .wen_wd        (wen_wr_data),
        .wsts_we       (wsts_wr_en),
        .wsts_wd       (wsts_wr_data),
        .wake_en       (wake_en),
        .wake_sts      (wake_sts)
    );

    irq_status_calc #(.NUM_STREAMS(NUM_STREAMS), .WAKE_W(WAKE_W)) u_calc (
        .stream_done (stream_done),
        .rsp_irq     (rsp_irq),
        .rsp_ovr     (rsp_ovr),
        .wake_en     (wake_en),
        .wake_sts    (wake_sts),
        .ctl         (int_ctl),
        .status      (int_status)
    );

    assign level    = int_status[GLB_BIT] & int_ctl[GLB_BIT];
    assign irq_line = level & ~msg_mode;

    irq_notify_fsm u_ntf (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .msg_mode (msg_mode),
        .irq_msg  (irq_msg)
    );

    // R8: the line is quiet in message mode
    a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode |-> !irq_line);

    // R6: the line never rises without the global enable
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> int_ctl[GLB_BIT]);

    // R5: the global bit needs a source that is also enabled
    a_r5_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_status[GLB_BIT] |-> ((int_status[GLB_BIT-1:0] & int_ctl[GLB_BIT-1:0]) != '0));

    // R3: unused middle status bits stay low
    a_r3_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[CTL_SUM_BIT-1:0] & ~STREAM_BITS[CTL_SUM_BIT-1:0]) == '0);
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    localparam logic [31:0] MASK = 32'hC00000FF;

    typedef struct {
        logic [31:0] sts;
        logic        line;
        logic        msg;
        logic [31:0] ctl;
        logic [14:0] wen;
        logic [14:0] wsts;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, rsp_irq, rsp_ovr, ctl_wr_en, wen_wr_en, wsts_wr_en, msg_mode;
    logic [14:0] codec_present, wen_wr_data, wsts_wr_data;
    logic [7:0]  stream_done;
    logic [31:0] ctl_wr_data;
    logic [31:0] int_ctl, int_status;
    logic [14:0] wake_en, wake_sts;
    logic        irq_line, irq_msg;

    logic        n_rst, n_irq, n_ovr, n_ctl_we, n_wen_we, n_wsts_we, n_msg;
    logic [14:0] n_cp, n_wen_wd, n_wsts_wd;
    logic [7:0]  n_sd;
    logic [31:0] n_ctl_wd;

    logic [31:0] m_ctl;
    logic [14:0] m_wen, m_wsts;
    logic        m_high, m_fire;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .codec_present(codec_present),
        .rsp_irq(rsp_irq), .rsp_ovr(rsp_ovr), .stream_done(stream_done),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .wen_wr_en(wen_wr_en), .wen_wr_data(wen_wr_data),
        .wsts_wr_en(wsts_wr_en), .wsts_wr_data(wsts_wr_data),
        .msg_mode(msg_mode), .int_ctl(int_ctl), .wake_en(wake_en),
        .wake_sts(wake_sts), .int_status(int_status),
        .irq_line(irq_line), .irq_msg(irq_msg)
    );

    task automatic cyc(input string tag);
        exp_t        e;
        logic [31:0] s;
        logic        lvl;
        @(negedge clk);
        rst_n = n_rst; codec_present = n_cp; rsp_irq = n_irq; rsp_ovr = n_ovr;
        stream_done = n_sd; msg_mode = n_msg;
        ctl_wr_en = n_ctl_we; ctl_wr_data = n_ctl_wd;
        wen_wr_en = n_wen_we; wen_wr_data = n_wen_wd;
        wsts_wr_en = n_wsts_we; wsts_wr_data = n_wsts_wd;
        n_ctl_we = 0; n_wen_we = 0; n_wsts_we = 0;
        #1;
        s      = 32'h0;
        s[7:0] = stream_done;
        s[30]  = rsp_irq | rsp_ovr | (|(m_wsts & m_wen));
        s[31]  = |(s[30:0] & m_ctl[30:0]);
        lvl    = s[31] & m_ctl[31];
        if (rst_n) begin
            e.sts = s; e.line = lvl & ~msg_mode; e.msg = m_fire;
            e.ctl = m_ctl; e.wen = m_wen; e.wsts = m_wsts; e.tag = tag;
            q.push_back(e);
        end
        if (!rst_n) begin
            m_ctl = 0; m_wen = 0; m_wsts = codec_present; m_high = 0; m_fire = 0;
        end else begin
            m_fire = lvl & msg_mode & ~m_high;
            m_high = lvl;
            if (ctl_wr_en)  m_ctl  = ctl_wr_data & MASK;
            if (wen_wr_en)  m_wen  = wen_wr_data;
            if (wsts_wr_en) m_wsts = m_wsts & ~wsts_wr_data;
        end
    endtask

    // monitor: pops expected items and compares them mid-cycle
    initial begin
        exp_t e;
        bit   bad;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                bad = 0;
                if (int_status !== e.sts) begin
                    $display("FAIL %s int_status: actual=%h expected=%h", e.tag, int_status, e.sts); bad = 1;
                end
                if (irq_line !== e.line) begin
                    $display("FAIL %s irq_line: actual=%b expected=%b", e.tag, irq_line, e.line); bad = 1;
                end
                if (irq_msg !== e.msg) begin
                    $display("FAIL %s irq_msg: actual=%b expected=%b", e.tag, irq_msg, e.msg); bad = 1;
                end
                if (int_ctl !== e.ctl) begin
                    $display("FAIL %s int_ctl: actual=%h expected=%h", e.tag, int_ctl, e.ctl); bad = 1;
                end
                if (wake_en !== e.wen) begin
                    $display("FAIL %s wake_en: actual=%h expected=%h", e.tag, wake_en, e.wen); bad = 1;
                end
                if (wake_sts !== e.wsts) begin
                    $display("FAIL %s wake_sts: actual=%h expected=%h", e.tag, wake_sts, e.wsts); bad = 1;
                end
                if (bad) n_fail++;
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic do_reset(input logic [14:0] cp);
        n_rst = 0; n_cp = cp;
        for (int i = 0; i < 3; i++) cyc("R1");
        n_rst = 1;
    endtask

    initial begin
        n_rst = 0; n_cp = 0; n_irq = 0; n_ovr = 0; n_sd = 0; n_msg = 0;
        n_ctl_we = 0; n_ctl_wd = 0; n_wen_we = 0; n_wen_wd = 0;
        n_wsts_we = 0; n_wsts_wd = 0;
        m_ctl = 0; m_wen = 0; m_wsts = 0; m_high = 0; m_fire = 0;

        // R1: reset state with codecs 0 and 2 present
        do_reset(15'h0005);
        cyc("R1");

        // R2: write all ones, only masked bits stick
        n_ctl_we = 1; n_ctl_wd = 32'hFFFF_FFFF; cyc("R2");
        cyc("R2");
        n_ctl_we = 1; n_ctl_wd = 32'h0; cyc("R2");

        // R3: stream mirrors, same cycle
        n_sd = 8'h01; cyc("R3");
        n_sd = 8'h80; cyc("R3");
        n_sd = 8'hA5; cyc("R3");
        n_sd = 8'h00; cyc("R3");

        // R4: the three controller-summary sources
        n_irq = 1; cyc("R4");
        n_irq = 0; n_ovr = 1; cyc("R4");
        n_ovr = 0; cyc("R4");
        n_wen_we = 1; n_wen_wd = 15'h0002; cyc("R4");
        cyc("R4");
        n_wen_we = 1; n_wen_wd = 15'h0004; cyc("R4");
        cyc("R4");
        n_wen_we = 1; n_wen_wd = 15'h0000; cyc("R4");

        // R5: summary enable without global enable
        n_ctl_we = 1; n_ctl_wd = 32'h4000_0000; cyc("R5");
        n_irq = 1; cyc("R5");
        n_irq = 0;
        n_ctl_we = 1; n_ctl_wd = 32'h8000_0000; n_sd = 8'hFF; cyc("R5");
        cyc("R5");
        n_ctl_we = 1; n_ctl_wd = 32'h0000_0002; n_sd = 8'h01; cyc("R5");
        cyc("R5");
        n_sd = 8'h02; cyc("R5");

        // R6: line mode follows level same cycle
        n_ctl_we = 1; n_ctl_wd = 32'h8000_0002; cyc("R6");
        cyc("R6");
        n_sd = 8'h00; cyc("R6");
        n_sd = 8'h02; cyc("R6");
        n_sd = 8'h00; cyc("R6");

        // R7: wake enable width and write-1-to-clear
        n_wen_we = 1; n_wen_wd = 15'h7FFF; cyc("R7");
        n_wsts_we = 1; n_wsts_wd = 15'h0000; cyc("R7");
        n_wsts_we = 1; n_wsts_wd = 15'h0001; cyc("R7");
        cyc("R7");
        n_wsts_we = 1; n_wsts_wd = 15'h7FFF; cyc("R7");
        cyc("R7");
        n_wen_we = 1; n_wen_wd = 15'h0000; cyc("R7");

        // R8: message mode, held level gives one pulse
        n_msg = 1; n_ctl_we = 1; n_ctl_wd = 32'h8000_0001; cyc("R8");
        cyc("R8");
        n_sd = 8'h01;
        for (int i = 0; i < 6; i++) cyc("R8");

        // R9: re-arm after a low edge
        n_sd = 8'h00; cyc("R9");
        cyc("R9");
        n_sd = 8'h01; cyc("R9");
        cyc("R9");
        cyc("R9");
        // R9: enter message mode while level already high
        n_msg = 0; n_sd = 8'h00; cyc("R9");
        n_sd = 8'h01; cyc("R9");
        cyc("R9");
        n_msg = 1; cyc("R9");
        cyc("R9");
        cyc("R9");

        // R1: second reset with a different codec set
        do_reset(15'h7001);
        n_sd = 8'h00; n_msg = 0;
        cyc("R1");
        cyc("R1");

        @(negedge clk);
        #4;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule